// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

The bridge sits between a processor-side request port and a memory-side bus port. Every processor access it receives is aimed at one of two 32 MB alias windows, based at 0x22000000 and 0x42000000. In these windows each aligned 32-bit alias word stands for a single bit of ordinary backing memory. The bridge converts the alias address into a backing address and a bit position. A read becomes one memory read, and the bridge returns the chosen bit as the value 0 or 1. A write becomes a locked read-modify-write that forces that one bit to bit 0 of the write data and leaves every other bit of the unit as it was.

Byte, halfword and word access sizes are supported. The size controls three things: how the backing address is aligned, how many bits of the alias address form the bit index, and which byte lanes the memory side enables. The bridge handles one alias transaction at a time. The processor holds its request until the bridge pulses ready, which happens once the final memory phase completes.

Top module: `bitband_bridge`

## Requirements
- R1: The backing address is alias bits 31:29 kept in place, ORed with alias bits 24:5 moved down to bits 19:0. All other bits are zero. Bit 0 is then cleared for halfword accesses, and bits 1:0 are cleared for word accesses. The address stays constant while a memory request waits for acknowledge.
- R2: The bit index is alias bits 6:2, masked to 3 bits for byte accesses, 4 bits for halfword accesses and 5 bits for word accesses. On the 32-bit little-endian data bus, the selected bit sits at position 8×addr[1:0]+index for a byte, 16×addr[1]+index for a halfword and index for a word.
- R3: An alias read performs exactly one memory read and no write. It returns 32'h1 when the selected bit is set and 32'h0 when it is clear.
- R4: An alias write reads the unit and then writes it back to the same address. The selected bit becomes write-data bit 0, every other bit of the unit is unchanged, and write-data bits 31:1 have no effect.
- R5: The memory size equals the alias access size, encoded as 0 for byte, 1 for halfword and 2 for word. The byte enables are 1<<addr[1:0] for a byte, 4'b0011 or 4'b1100 (chosen by addr[1]) for a halfword, and 4'b1111 for a word.
- R6: Lock is asserted during every memory request of an alias write, from the read phase through the write phase, with no gap between them. Lock is never asserted during an alias read.
- R7: Ready is a single-cycle pulse. It is raised only after the last memory phase has been acknowledged, and never while a memory request is outstanding. With memory latency L, a write takes at least 2L+2 cycles.
- R8: A memory error is reported on the processor error output. An error in the read phase of a write suppresses the write phase and leaves memory unchanged. A transaction without an error reports error 0.
- R9: During reset, memory request, lock and ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuReq | input | 1 | Alias request, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2 word |
| cpuAddr | input | 32 | Alias address |
| cpuWdata | input | 32 | Write data; only bit 0 is used |
| cpuReady | output | 1 | Completion pulse |
| cpuRdata | output | 32 | Read result, 0 or 1 |
| cpuErr | output | 1 | Error for the finished transaction |
| memReq | output | 1 | Memory request, held until memAck |
| memWrite | output | 1 | Memory phase is a write |
| memSize | output | 2 | Memory access size |
| memAddr | output | 32 | Backing address |
| memBe | output | 4 | Byte-lane enables |
| memWdata | output | 32 | Modified unit for the write phase |
| memLock | output | 1 | Locks the bus across the read-modify-write |
| memRdata | input | 32 | Memory read data |
| memAck | input | 1 | Memory phase complete |
| memErr | input | 1 | Memory error, valid with memAck |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- An odd halfword target: a design that skips the alignment or the lane offset would modify a bit in the wrong byte.
- A byte in the top lane: a design without the 8×addr[1:0] lane offset would return bit 5 of lane 0 instead of bit 29.
- Write data of 32'hFFFFFFFE: a design that tests the whole word for nonzero would set the bit instead of clearing it.
- The upper window at 0x42000000: a design that dropped the region bits would address the wrong backing memory.
- A read error on a write: a design that ignored it would still write back stale data.
- Slow memory: with a multi-cycle acknowledge, a premature ready or a gap in lock would show.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int POS_W    = $clog2(DATA_W);
  localparam int SHIFT_W  = $clog2(8) + $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic setErr;
    logic active;
    logic writePhase;
  } ctlStrobes_t;
endpackage

// File: rtl/bitband_datapath.sv
module bitband_datapath
  import bitband_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 3,
  parameter int SPAN_W   = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [1:0]          cpuSize,
  input  logic                cpuWbit,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memAck,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [1:0]          memSize,
  output logic [LANES-1:0]    memBe,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                cpuErr
);
  localparam int LOW_W = SPAN_W - SHIFT_W;
  localparam int PAD_W = ADDR_W - REGION_W - LOW_W;

  logic [ADDR_W-1:0] tgtRaw, tgtAligned, tgtReg;
  logic [POS_W-1:0]  idxRaw, posNext, posReg;
  logic [1:0]        sizeReg;
  logic              wbitReg, bitReg, errReg;
  logic [DATA_W-1:0] rdCap;
  logic              unusedAddrBits;

  assign unusedAddrBits = ^{cpuAddr[ADDR_W-REGION_W-1:SPAN_W], cpuAddr[1:0]};

  // alias -> backing address: region bits kept, offset divided by 32
  assign tgtRaw = {cpuAddr[ADDR_W-1 -: REGION_W], {PAD_W{1'b0}}, cpuAddr[SPAN_W-1:SHIFT_W]};
  assign idxRaw = cpuAddr[POS_W+1:2];

  always_comb begin
    tgtAligned = tgtRaw;
    posNext    = idxRaw;
    case (cpuSize)
      SZ_BYTE: posNext = {tgtRaw[1:0], idxRaw[2:0]};
      SZ_HALF: begin
        tgtAligned[0] = 1'b0;
        posNext       = {tgtRaw[1], idxRaw[3:0]};
      end
      default: tgtAligned[1:0] = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtReg  <= '0;
      posReg  <= '0;
      sizeReg <= SZ_WORD;
      wbitReg <= 1'b0;
      rdCap   <= '0;
      bitReg  <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      if (strobes.load) begin
        tgtReg  <= tgtAligned;
        posReg  <= posNext;
        sizeReg <= cpuSize;
        wbitReg <= cpuWbit;
        errReg  <= 1'b0;
      end
      if (strobes.capture) begin
        rdCap  <= memRdata;
        bitReg <= memRdata[posReg];
      end
      if (strobes.setErr) errReg <= 1'b1;
    end
  end

  always_comb begin
    memWdata         = rdCap;
    memWdata[posReg] = wbitReg;
  end

  always_comb begin
    case (sizeReg)
      SZ_BYTE: memBe = LANES'(1) << tgtReg[1:0];
      SZ_HALF: memBe = tgtReg[1] ? 4'b1100 : 4'b0011;
      default: memBe = '1;
    endcase
  end

  assign memAddr  = tgtReg;
  assign memSize  = sizeReg;
  assign cpuRdata = {{(DATA_W-1){1'b0}}, bitReg};
  assign cpuErr   = errReg;

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && !memAck) |=> $stable(memAddr));
  assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && sizeReg == SZ_BYTE) |-> ($countones(memBe) == 1));
  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writePhase |-> ($countones(memWdata ^ rdCap) <= 1));
endmodule

// File: rtl/bitband_control.sv
module bitband_control
  import bitband_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic        memAck,
  input  logic        memErr,
  output ctlStrobes_t strobes,
  output logic        memReq,
  output logic        memWrite,
  output logic        memLock,
  output logic        cpuReady
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} state_e;

  state_e stateQ, stateD;
  logic   isWriteQ;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    case (stateQ)
      ST_IDLE: if (cpuReq) begin
        strobes.load = 1'b1;
        stateD       = ST_READ;
      end
      ST_READ: if (memAck) begin
        strobes.capture = 1'b1;
        strobes.setErr  = memErr;
        stateD = (isWriteQ && !memErr) ? ST_WRITE : ST_RESP;
      end
      ST_WRITE: if (memAck) begin
        strobes.setErr = memErr;
        stateD         = ST_RESP;
      end
      default: stateD = ST_IDLE;
    endcase
    strobes.active     = (stateQ == ST_READ) || (stateQ == ST_WRITE);
    strobes.writePhase = (stateQ == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      isWriteQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobes.load) isWriteQ <= cpuWrite;
    end
  end

  assign memReq   = strobes.active;
  assign memWrite = strobes.writePhase;
  assign memLock  = strobes.active && isWriteQ;
  assign cpuReady = (stateQ == ST_RESP);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWrite)));
  assert_lock_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> memLock);
  assert_lock_gapless_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memLock && memAck && !memErr) |=> (memReq && memWrite && memLock));
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);
  assert_ready_not_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !memReq);
  assert_skip_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memAck && memErr) |=> !memReq);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 3,
  parameter int SPAN_W   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [1:0]        cpuSize,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic              cpuReady,
  output logic [31:0]       cpuRdata,
  output logic              cpuErr,
  output logic              memReq,
  output logic              memWrite,
  output logic [1:0]        memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  output logic              memLock,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr
);
  ctlStrobes_t strobes;
  logic        unusedWdataBits;

  assign unusedWdataBits = ^cpuWdata[31:1];

  bitband_control ctl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .memAck(memAck), .memErr(memErr), .strobes(strobes),
    .memReq(memReq), .memWrite(memWrite), .memLock(memLock), .cpuReady(cpuReady)
  );

  bitband_datapath #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .SPAN_W(SPAN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .cpuSize(cpuSize), .cpuWbit(cpuWdata[0]), .memRdata(memRdata), .memAck(memAck),
    .memAddr(memAddr), .memSize(memSize), .memBe(memBe), .memWdata(memWdata),
    .cpuRdata(cpuRdata), .cpuErr(cpuErr)
  );
endmodule

// File: tb/bitband_bridge_tb_top.sv
`timescale 1ns/1ps
module bitband_bridge_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [1:0] cpuSize = 2'd2;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady, cpuErr, memReq, memWrite, memLock;
  logic [31:0] cpuRdata, memAddr, memWdata;
  logic [1:0] memSize;
  logic [3:0] memBe;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0, memErr = 1'b0;

  int checks = 0, fails = 0;
  int memLat = 0, waitCnt = 0, readCount = 0, writeCount = 0, lockBad = 0, readyBusy = 0;
  logic errOnRead = 1'b0, curIsWrite = 1'b0;
  logic [31:0] lastAddr;
  logic [1:0]  lastSize;
  logic [3:0]  lastBe;
  logic [31:0] memArr [16];
  logic [31:0] gotRdata;
  logic gotErr;
  int cycles, extraReady = 0;

  bitband_bridge dut_i (.*);

  always #2 clk = ~clk;

  // memory model with configurable acknowledge latency
  always @(posedge clk) begin
    if (memReq && (memLock !== curIsWrite)) lockBad <= lockBad + 1;
    if (memReq && cpuReady) readyBusy <= readyBusy + 1;
    if (!rstN) begin
      memAck <= 1'b0; waitCnt <= 0;
    end else if (memAck) begin
      memAck <= 1'b0; waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt >= memLat) begin
        memAck <= 1'b1; lastAddr <= memAddr; lastSize <= memSize; lastBe <= memBe;
        if (memWrite) begin
          for (int l = 0; l < 4; l++)
            if (memBe[l]) memArr[memAddr[5:2]][8*l +: 8] <= memWdata[8*l +: 8];
          writeCount <= writeCount + 1; memErr <= 1'b0;
        end else begin
          memRdata <= memArr[memAddr[5:2]]; memErr <= errOnRead;
          readCount <= readCount + 1;
        end
      end else waitCnt <= waitCnt + 1;
    end
  end

  function automatic logic [31:0] refTgt(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] t = (a & 32'hE000_0000) | ((a & 32'h01FF_FFFF) >> 5);
    if (sz == 2'd1) t = t & ~32'd1;
    else if (sz != 2'd0) t = t & ~32'd3;
    return t;
  endfunction

  function automatic int refPos(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] t = refTgt(a, sz);
    int ix = int'(a >> 2);
    if (sz == 2'd0) return 8 * int'(t % 4) + (ix % 8);
    if (sz == 2'd1) return 16 * int'((t / 2) % 2) + (ix % 16);
    return ix % 32;
  endfunction

  function automatic logic [3:0] refBe(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] t = refTgt(a, sz);
    if (sz == 2'd0) return 4'b0001 << (t % 4);
    if (sz == 2'd1) return (t % 4 == 2) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runTxn(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd);
    @(negedge clk);
    curIsWrite = wr; cpuWrite = wr; cpuSize = sz; cpuAddr = a; cpuWdata = wd; cpuReq = 1'b1;
    cycles = 0;
    do begin @(negedge clk); cycles++; end while (!cpuReady && cycles < 2000);
    if (cycles >= 2000) checkEq("R7 ready timeout", 32'd0, 32'd1);
    gotRdata = cpuRdata; gotErr = cpuErr; cpuReq = 1'b0;
    @(negedge clk);
    if (cpuReady) extraReady++;
  endtask

  task automatic testReset();
    checkEq("R9 memReq in reset", {31'b0, memReq}, 32'd0);
    checkEq("R9 memLock in reset", {31'b0, memLock}, 32'd0);
    checkEq("R9 cpuReady in reset", {31'b0, cpuReady}, 32'd0);
  endtask

  task automatic testWordRead();
    int rc;
    memArr[4] = 32'h0000_0080;
    rc = readCount;
    runTxn(1'b0, 2'd2, 32'h2200_021C, 32'h0);
    checkEq("R3 word read set bit", gotRdata, 32'h1);
    checkEq("R1 word target addr", lastAddr, refTgt(32'h2200_021C, 2'd2));
    runTxn(1'b0, 2'd2, 32'h2200_0218, 32'h0);
    checkEq("R3 word read clear bit", gotRdata, 32'h0);
    checkEq("R3 one read per access", readCount - rc, 32'd2);
    checkEq("R3 no write on read", writeCount, 32'd0);
    checkEq("R8 no error reported", {31'b0, gotErr}, 32'd0);
  endtask

  task automatic testByteRead();
    logic [31:0] a = 32'h2200_0274;
    memArr[4] = 32'h0000_0000;
    memArr[4][refPos(a, 2'd0)] = 1'b1;
    runTxn(1'b0, 2'd0, a, 32'h0);
    checkEq("R2 byte top-lane bit", gotRdata, 32'h1);
    checkEq("R1 byte target addr", lastAddr, 32'h2000_0013);
    checkEq("R5 byte size", {30'b0, lastSize}, 32'd0);
    checkEq("R5 byte enables", {28'b0, lastBe}, {28'b0, refBe(a, 2'd0)});
    memArr[4] = 32'h0000_0020;
    runTxn(1'b0, 2'd0, a, 32'h0);
    checkEq("R2 byte lane0 bit5 not chosen", gotRdata, 32'h0);
  endtask

  task automatic testHalfWrite();
    logic [31:0] a = 32'h2200_0170;
    logic [31:0] exp = 32'h0F0F_0F0F;
    int wc = writeCount;
    memArr[2] = exp;
    exp[refPos(a, 2'd1)] = 1'b1;
    runTxn(1'b1, 2'd1, a, 32'h1);
    checkEq("R4 half write sets bit", memArr[2], exp);
    checkEq("R1 half addr aligned", lastAddr, 32'h2000_000A);
    checkEq("R5 half enables", {28'b0, lastBe}, 32'hC);
    checkEq("R5 half size", {30'b0, lastSize}, 32'd1);
    checkEq("R4 one write", writeCount - wc, 32'd1);
    checkEq("R6 lock pattern", lockBad, 32'd0);
  endtask

  task automatic testUpperWindow();
    logic [31:0] a = 32'h4200_048C;
    memArr[9] = 32'hFFFF_FFFF;
    runTxn(1'b1, 2'd2, a, 32'h0);
    checkEq("R4 word write clears bit", memArr[9], 32'hFFFF_FFF7);
    checkEq("R1 upper window addr", lastAddr, 32'h4000_0024);
    checkEq("R5 word enables", {28'b0, lastBe}, 32'hF);
  endtask

  task automatic testUpperDataIgnored();
    logic [31:0] a = 32'h2200_0274;
    logic [31:0] exp = 32'hFFFF_FFFF;
    memArr[4] = exp;
    exp[refPos(a, 2'd0)] = 1'b0;
    runTxn(1'b1, 2'd0, a, 32'hFFFF_FFFE);
    checkEq("R4 upper wdata bits ignored", memArr[4], exp);
    memArr[4] = 32'h0;
    runTxn(1'b1, 2'd0, 32'h2200_0208, 32'h1);
    checkEq("R4 byte lane0 bit set", memArr[4], 32'h0000_0004);
    checkEq("R5 lane0 enable", {28'b0, lastBe}, 32'h1);
  endtask

  task automatic testErrors();
    int wc;
    errOnRead = 1'b1;
    runTxn(1'b0, 2'd2, 32'h2200_021C, 32'h0);
    checkEq("R8 read error reported", {31'b0, gotErr}, 32'd1);
    memArr[5] = 32'h1234_5678;
    wc = writeCount;
    runTxn(1'b1, 2'd2, 32'h2200_02A0, 32'h1);
    checkEq("R8 write error reported", {31'b0, gotErr}, 32'd1);
    checkEq("R8 write phase skipped", writeCount - wc, 32'd0);
    checkEq("R8 memory unchanged", memArr[5], 32'h1234_5678);
    errOnRead = 1'b0;
    runTxn(1'b0, 2'd2, 32'h2200_021C, 32'h0);
    checkEq("R8 error cleared next txn", {31'b0, gotErr}, 32'd0);
  endtask

  task automatic testSlowMemory();
    memLat = 5;
    memArr[3] = 32'h0;
    runTxn(1'b1, 2'd2, 32'h2200_0184, 32'h1);
    checkEq("R7 write waits both phases", {31'b0, (cycles >= 12)}, 32'd1);
    checkEq("R4 slow write result", memArr[3], 32'h0000_0002);
    runTxn(1'b0, 2'd2, 32'h2200_0184, 32'h0);
    checkEq("R3 slow read result", gotRdata, 32'h1);
    checkEq("R6 lock held, none on read", lockBad, 32'd0);
    checkEq("R7 no ready while busy", readyBusy, 32'd0);
    checkEq("R7 ready single pulse", extraReady, 32'd0);
    memLat = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) memArr[i] = 32'h0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWordRead();
    testByteRead();
    testHalfWrite();
    testUpperWindow();
    testUpperDataIgnored();
    testErrors();
    testSlowMemory();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule